// File: doc/BRIEF.md
# Two-Port GPIO Register Block with Bit-Banged Flash Strobes and Sensor Clock

This block gives a processor a word-addressed register window holding two general-purpose I/O ports, named A and D, plus a small set of scratch words. Each port has an output word, an enable word and a readback word. The readback shows the driven value masked by its enable, with a few external input pins merged in at fixed bit positions.

Port A is wired to a NAND flash. Three bits of its output word are decoded into the flash control strobes: address latch, command latch and chip enable. The flash ready/busy pin is read back through port A. Port D bit-banges a serial temperature sensor. Software toggles one output bit to make the serial clock, and presents serial data on another bit. Each write that changes the clock bit emits a one-cycle edge event toward the sensor model. The event carries the new clock level and the data bit. The sensor's returned data bit is read back through port D.

Top module: `gpio_bitbang`

## Requirements
- R1: The register word index is the byte address shifted right by two. Address bits 1:0 have no effect on which word is read or written.
- R2: Every word index below 23, other than 1 and 17, is a read/write register. A write takes effect at the clock edge it is presented on, and a later read returns the written value.
- R3: Reading word 1 returns (word 0 AND word 2), with the flash ready input OR-ed into bit 7.
- R4: The flash strobes follow word 0 from the cycle after a write to it: address latch = bit 6, command latch = bit 5, chip enable = bit 4. A write to any other word leaves them unchanged.
- R5: Reading word 17 returns (word 16 AND word 18), with the sensor serial input OR-ed into bit 4.
- R6: A write to word 16 whose bit 1 differs from the stored bit 1 raises the edge event for exactly the next cycle. From that cycle the clock level output equals the written bit 1, and the sensor data output equals the written bit 4.
- R7: A write to word 16 whose bit 1 equals the stored bit 1 raises no event and leaves the clock level and sensor data outputs unchanged. No write to another word raises an event.
- R8: Writes to words 1 and 17 are ignored. The readback of those words is unchanged by them.
- R9: Word indices 23 to 31 read as zero, and writes to them change nothing.
- R10: Reset clears every register, the flash strobes, the edge event, the clock level and the sensor data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 7 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one word per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| nandRdyIn | input | 1 | Flash ready/busy pin |
| nandAle | output | 1 | Flash address latch enable |
| nandCle | output | 1 | Flash command latch enable |
| nandCe | output | 1 | Flash chip enable |
| sensDataIn | input | 1 | Serial data returned by the sensor |
| sensClkEvt | output | 1 | One-cycle pulse on each serial clock change |
| sensClkLvl | output | 1 | Serial clock level after the last change |
| sensDataOut | output | 1 | Serial data bit latched with the last change |

## Verification
The bench first writes a distinct pattern to all 32 word indices, using every value of the two byte-lane address bits. It then reads every index back under all four combinations of the two input pins. This separates plain storage words, masked readback words, read-only words and words outside the window. A second sweep goes through the port A output and enable bits and every strobe combination, so that each strobe is shown to come from its own bit. A third sweep writes port D with every pairing of clock and data bits, including repeated levels. This tells a true clock change apart from a rewrite of the same level, and shows that the data bit is taken only with the change.

// File: rtl/gpio_bb_pkg.sv
package gpio_bb_pkg;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             wrStore;
    logic             wrPortD;
    logic             selInA;
    logic             selInD;
  } busCtl_t;
endpackage

// File: rtl/gpio_bb_ctrl.sv
module gpio_bb_ctrl
  import gpio_bb_pkg::*;
#(
  parameter int NUM_WORDS = 23,
  parameter int PA_IN     = 1,
  parameter int PD_OUT    = 16,
  parameter int PD_IN     = 17
) (
  input  logic [IDX_W+1:0] busAddr,
  input  logic             busWe,
  output busCtl_t          ctl
);
  logic [1:0]       unusedByteLane;
  logic [IDX_W-1:0] wordIdx;
  logic             inWin;
  logic             isInA;
  logic             isInD;

  assign unusedByteLane = busAddr[1:0];
  assign wordIdx = busAddr[IDX_W+1:2];
  assign inWin   = int'(wordIdx) < NUM_WORDS;
  assign isInA   = wordIdx == PA_IN[IDX_W-1:0];
  assign isInD   = wordIdx == PD_IN[IDX_W-1:0];

  always_comb begin
    ctl.idx     = wordIdx;
    ctl.selInA  = isInA;
    ctl.selInD  = isInD;
    ctl.wrStore = busWe && inWin && !isInA && !isInD;
    ctl.wrPortD = busWe && (wordIdx == PD_OUT[IDX_W-1:0]);
  end
endmodule

// File: rtl/gpio_bb_dp.sv
module gpio_bb_dp
  import gpio_bb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 23,
  parameter int PA_OUT    = 0,
  parameter int PA_OE     = 2,
  parameter int PD_OUT    = 16,
  parameter int PD_OE     = 18,
  parameter int RDY_BIT   = 7,
  parameter int SIN_BIT   = 4,
  parameter int SCLK_BIT  = 1,
  parameter int SDAT_BIT  = 4,
  parameter int ALE_BIT   = 6,
  parameter int CLE_BIT   = 5,
  parameter int CE_BIT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              nandRdyIn,
  input  logic              sensDataIn,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        nandStrobes,
  output logic              evt,
  output logic              evtLvl,
  output logic              evtData
);
  logic [DATA_W-1:0] regs [NUM_WORDS];
  logic              clkChange;

  assign clkChange = ctl.wrPortD && (wdata[SCLK_BIT] != regs[PD_OUT][SCLK_BIT]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) regs[i] <= '0;
      evt     <= 1'b0;
      evtLvl  <= 1'b0;
      evtData <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (ctl.wrStore && (ctl.idx == IDX_W'(i))) regs[i] <= wdata;
      end
      evt <= clkChange;
      if (clkChange) begin
        evtLvl  <= wdata[SCLK_BIT];
        evtData <= wdata[SDAT_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (ctl.idx == IDX_W'(i)) rdata = regs[i];
    end
    if (ctl.selInA) begin
      rdata = regs[PA_OUT] & regs[PA_OE];
      rdata[RDY_BIT] = rdata[RDY_BIT] | nandRdyIn;
    end
    if (ctl.selInD) begin
      rdata = regs[PD_OUT] & regs[PD_OE];
      rdata[SIN_BIT] = rdata[SIN_BIT] | sensDataIn;
    end
  end

  assign nandStrobes = {regs[PA_OUT][ALE_BIT], regs[PA_OUT][CLE_BIT], regs[PA_OUT][CE_BIT]};
endmodule

// File: rtl/gpio_bitbang.sv
module gpio_bitbang
  import gpio_bb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 23,
  parameter int PA_OUT    = 0,
  parameter int PA_IN     = 1,
  parameter int PA_OE     = 2,
  parameter int PD_OUT    = 16,
  parameter int PD_IN     = 17,
  parameter int PD_OE     = 18,
  parameter int RDY_BIT   = 7,
  parameter int SIN_BIT   = 4,
  parameter int SCLK_BIT  = 1,
  parameter int SDAT_BIT  = 4,
  parameter int ALE_BIT   = 6,
  parameter int CLE_BIT   = 5,
  parameter int CE_BIT    = 4,
  localparam int ADDR_W   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              nandRdyIn,
  output logic              nandAle,
  output logic              nandCle,
  output logic              nandCe,
  input  logic              sensDataIn,
  output logic              sensClkEvt,
  output logic              sensClkLvl,
  output logic              sensDataOut
);
  busCtl_t    ctl;
  logic [2:0] strobes;

  gpio_bb_ctrl #(
    .NUM_WORDS(NUM_WORDS), .PA_IN(PA_IN), .PD_OUT(PD_OUT), .PD_IN(PD_IN)
  ) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .ctl(ctl)
  );

  gpio_bb_dp #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .PA_OUT(PA_OUT), .PA_OE(PA_OE),
    .PD_OUT(PD_OUT), .PD_OE(PD_OE), .RDY_BIT(RDY_BIT), .SIN_BIT(SIN_BIT),
    .SCLK_BIT(SCLK_BIT), .SDAT_BIT(SDAT_BIT), .ALE_BIT(ALE_BIT),
    .CLE_BIT(CLE_BIT), .CE_BIT(CE_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wdata(busWdata),
    .nandRdyIn(nandRdyIn), .sensDataIn(sensDataIn), .rdata(busRdata),
    .nandStrobes(strobes), .evt(sensClkEvt), .evtLvl(sensClkLvl),
    .evtData(sensDataOut)
  );

  assign {nandAle, nandCle, nandCe} = strobes;
endmodule

// File: rtl/gpio_bb_chk.sv
module gpio_bb_chk (
  input logic        clk,
  input logic        rstN,
  input logic [6:0]  busAddr,
  input logic        busWe,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic        nandRdyIn,
  input logic        nandAle,
  input logic        nandCle,
  input logic        nandCe,
  input logic        sensDataIn,
  input logic        sensClkEvt,
  input logic        sensClkLvl,
  input logic        sensDataOut
);
  logic [4:0] idx;
  assign idx = busAddr[6:2];

  p_strobe_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && idx == 5'd0) |=> (nandAle == $past(busWdata[6]) &&
      nandCle == $past(busWdata[5]) && nandCe == $past(busWdata[4])));

  p_strobe_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && idx == 5'd0) |=> $stable({nandAle, nandCle, nandCe}));

  p_edge_evt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && idx == 5'd16 && busWdata[1] != sensClkLvl) |=>
      (sensClkEvt && sensClkLvl == $past(busWdata[1]) && sensDataOut == $past(busWdata[4])));

  p_same_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && idx == 5'd16 && busWdata[1] == sensClkLvl) |=>
      (!sensClkEvt && $stable({sensClkLvl, sensDataOut})));

  p_no_evt_other_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && idx == 5'd16) |=> !sensClkEvt);

  p_rdy_merge_r3: assert property (@(posedge clk) disable iff (!rstN)
    (idx == 5'd1 && nandRdyIn) |-> busRdata[7]);

  p_sin_merge_r5: assert property (@(posedge clk) disable iff (!rstN)
    (idx == 5'd17 && sensDataIn) |-> busRdata[4]);

  p_outside_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (idx >= 5'd23) |-> (busRdata == 32'd0));
endmodule

bind gpio_bitbang gpio_bb_chk u_chk (.*);

// File: tb/sim_gpio_bitbang.sv
`timescale 1ns/1ps
module sim_gpio_bitbang;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        nandRdyIn = 1'b0;
  logic        nandAle, nandCle, nandCe;
  logic        sensDataIn = 1'b0;
  logic        sensClkEvt, sensClkLvl, sensDataOut;

  always #2.5 clk = ~clk;

  gpio_bitbang u0 (.*);

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [31:0] mdl [32];
  logic mdlLvl = 1'b0;
  logic mdlDat = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRd(int i);
    logic [31:0] r;
    if (i >= 23) r = '0;
    else if (i == 1) begin r = mdl[0] & mdl[2]; r[7] = r[7] | nandRdyIn; end
    else if (i == 17) begin r = mdl[16] & mdl[18]; r[4] = r[4] | sensDataIn; end
    else r = mdl[i];
    return r;
  endfunction

  function automatic string tagOf(int i);
    if (i >= 23) return "R9";
    if (i == 1) return "R3/R8 (R3)";
    if (i == 17) return "R5/R8 (R5)";
    return "R2";
  endfunction

  task automatic wr(int i, logic [1:0] lane, logic [31:0] d);
    logic expEvt;
    expEvt = (i == 16) && (d[1] != mdlLvl);
    @(negedge clk);
    busAddr = {i[4:0], lane};
    busWe = 1'b1;
    busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    #1;
    if (i < 23 && i != 1 && i != 17) mdl[i] = d;
    if (expEvt) begin mdlLvl = d[1]; mdlDat = d[4]; end
    if (i == 16) begin
      if (expEvt) chk("R6 event", {31'd0, sensClkEvt}, 32'd1);
      else chk("R7 no event", {31'd0, sensClkEvt}, 32'd0);
    end else chk("R7 no event on other word", {31'd0, sensClkEvt}, 32'd0);
    chk("R6 level/data", {30'd0, sensClkLvl, sensDataOut}, {30'd0, mdlLvl, mdlDat});
    chk("R4 strobes", {29'd0, nandAle, nandCle, nandCe}, {29'd0, mdl[0][6], mdl[0][5], mdl[0][4]});
  endtask

  task automatic rd(int i, logic [1:0] lane, string req);
    @(negedge clk);
    busAddr = {i[4:0], lane};
    busWe = 1'b0;
    #1;
    chk(req, busRdata, expRd(i));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 outputs", {28'd0, nandAle, nandCle, nandCe, sensClkEvt}, 32'd0);
    chk("R10 serial", {30'd0, sensClkLvl, sensDataOut}, 32'd0);
    for (int i = 0; i < 32; i++) rd(i, 2'(i), "R10 readback");
    rstN = 1'b1;

    // R1/R2/R8/R9: pattern into every index with every byte lane
    for (int i = 0; i < 32; i++) wr(i, 2'(i), 32'hA5A5A5A5 ^ (i * 32'h01030507));
    for (int p = 0; p < 4; p++) begin
      nandRdyIn = p[0];
      sensDataIn = p[1];
      for (int i = 0; i < 32; i++) rd(i, 2'(p + i), tagOf(i));
    end
    // R1: same word read through every lane
    for (int l = 0; l < 4; l++) rd(5, 2'(l), "R1 lane");

    // R8: writes to read-only words leave readback unchanged
    wr(1, 2'd0, 32'hFFFFFFFF);
    wr(17, 2'd3, 32'hFFFFFFFF);
    rd(1, 2'd0, "R8 word1");
    rd(17, 2'd0, "R8 word17");

    // R3/R4: port A output/enable sweep with all strobe combinations
    for (int k = 0; k < 16; k++) begin
      wr(0, 2'(k), {24'h5A0000, k[3:0], 4'h3} ^ 32'h0F00_0000);
      wr(2, 2'd1, (k[0] ? 32'hFFFF_FF0F : 32'h0000_00F0) ^ {k[3:0], 28'd0});
      for (int r = 0; r < 2; r++) begin
        nandRdyIn = r[0];
        rd(1, 2'(r), "R3 masked readback");
      end
    end

    // R5/R6/R7: port D clock and data sweep
    wr(18, 2'd0, 32'h0000_00FF);
    for (int k = 0; k < 32; k++) begin
      wr(16, 2'(k), {24'd0, k[4:3], 1'b0, k[1], 2'b00, k[0] ^ k[2], 1'b0});
      for (int s = 0; s < 2; s++) begin
        sensDataIn = s[0];
        rd(17, 2'd0, "R5 masked readback");
      end
    end
    // R7: same level rewritten several times
    for (int k = 0; k < 3; k++) wr(16, 2'd0, {27'd0, k[0], 2'b00, mdlLvl, 1'b0});

    // R9: outside window writes leave storage words intact
    wr(30, 2'd2, 32'hDEADBEEF);
    rd(30, 2'd0, "R9 outside");
    rd(3, 2'd0, "R9 neighbour intact");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule